// File: doc/BRIEF.md
# Peripheral Clock Enable Divider Pool

This block keeps a shared pool of clock dividers, all running from one peripheral source clock, and hands their outputs to a set of peripheral consumer channels. The pool mixes four kinds of divider: plain integer dividers 8 bits wide, plain integer dividers 16 bits wide, and two kinds of fractional divider with a 16-bit or 24-bit integer part plus a 5-bit fraction. The number of dividers of each kind is a parameter, and so is the number of consumer channels.

One write port sets a divider's integer value, fraction and enable bit. A divider is addressed by a type code and an index within that type. A second write port maps a consumer channel onto a divider, using the same type code and index. Each channel receives a one-cycle enable pulse, never a derived clock. The pulse passes through a gating stage, so it reaches the channel only while the channel is mapped. A divider can belong to only one channel at a time. A request to take a divider that another channel already holds is refused and flagged.

Top module: `clkdiv_pool`

## Requirements
- R1: While reset is held, and after it is released, no channel is mapped, every divider is disabled, `pclk_en` is all zero and `map_conflict` is low.
- R2: An enabled integer divider (type code 0 = 8-bit, type code 1 = 16-bit) with value N produces one pulse every N+1 source cycles. N = 0 gives a pulse on every cycle. The fraction field has no effect on these types.
- R3: An enabled fractional divider (type code 2 = 16-bit integer, type code 3 = 24-bit integer, each with a 5-bit fraction F) makes every period N+1 or N+2 cycles long. Any 32 consecutive periods last exactly 32*(N+1)+F cycles.
- R4: A channel selects a divider by a 2-bit type code and a 5-bit index within that type. Any divider can be routed to any channel. An index at or above the count for its type selects nothing, so that channel produces no pulses.
- R5: A write that enables a disabled divider with value N, taking effect at clock edge E, gives the first pulse on `pclk_en` just after edge E+N+1.
- R6: A new value written to an enabled divider leaves the period in progress unchanged. The new value sets the length of the period that follows.
- R7: A disabled divider produces no pulses. Disabling clears its counter and fraction accumulator, so a later enable again obeys R5.
- R8: A request to map a channel onto a divider that a different channel holds is refused. The channel's mapping is left unchanged, and `map_conflict` is high for the single cycle after the request. Remapping a channel to the divider it already holds, and unmapping, are always accepted.
- R9: `pclk_en[c]` is registered. It pulses one cycle after the selected divider's terminal count, and only while channel c is mapped. An unmapped channel never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral source clock shared by all dividers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Divider configuration write strobe |
| cfg_type | input | 2 | Type code of the divider being written |
| cfg_idx | input | 5 | Index of the divider within its type |
| cfg_int | input | 24 | Integer divide value N (upper bits unused on narrower types) |
| cfg_frac | input | 5 | Fraction F (used only by the fractional types) |
| cfg_enable | input | 1 | Enable bit written with the configuration |
| map_we | input | 1 | Channel mapping write strobe |
| map_chan | input | CH_W | Channel being mapped |
| map_type | input | 2 | Type code of the requested divider |
| map_idx | input | 5 | Index of the requested divider |
| map_on | input | 1 | 1 maps the channel, 0 unmaps it |
| map_conflict | output | 1 | Pulses when a mapping request is refused |
| pclk_en | output | NUM_CH | One-cycle enable pulse per consumer channel |

## Verification
A divider's terminal count is its state after an edge, and the channel output register adds one more edge. The first pulse after an enable written at edge E is therefore sampled at the falling edge after E+N+1, and `map_conflict` is sampled at the falling edge right after the mapping edge. Steady-state behaviour is measured as the number of falling edges between successive pulses, so this one-edge output delay drops out. The fractional averages are summed over 32 periods, and the first period after each enable is left out of the sum. For a live update, the write is issued at the falling edge where a pulse is seen, which puts it one cycle into a period. The current period then keeps its old length and the following period takes the new length.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int SEL_W  = 5;
    localparam int FRAC_W = 5;
    localparam int VAL_W  = 24;

    typedef enum logic [1:0] {
        DT_INT8   = 2'd0,
        DT_INT16  = 2'd1,
        DT_FRAC16 = 2'd2,
        DT_FRAC24 = 2'd3
    } div_type_e;

    typedef struct packed {
        div_type_e        typ;
        logic [SEL_W-1:0] idx;
    } div_sel_t;

    function automatic int type_width(div_type_e t);
        case (t)
            DT_INT8:   return 8;
            DT_INT16:  return 16;
            DT_FRAC16: return 16;
            default:   return 24;
        endcase
    endfunction

    function automatic bit type_has_frac(div_type_e t);
        return (t == DT_FRAC16) || (t == DT_FRAC24);
    endfunction

endpackage

// File: rtl/clkdiv_unit.sv
module clkdiv_unit
    import clkdiv_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [INT_W-1:0]  wr_int,
    input  logic [FRAC_W-1:0] wr_frac,
    input  logic              wr_enable,
    output logic              tick
);
    localparam int CNT_W = INT_W + 1;

    logic              en_q, stretch_q;
    logic [CNT_W-1:0]  cnt_q, limit;
    logic [INT_W-1:0]  shd_int_q, act_int_q, nxt_int;
    logic [FRAC_W-1:0] shd_frac_q, act_frac_q, nxt_frac, acc_q;
    logic [FRAC_W:0]   acc_sum;

    assign nxt_int  = wr_hit ? wr_int  : shd_int_q;
    assign nxt_frac = wr_hit ? wr_frac : shd_frac_q;
    assign limit    = {1'b0, act_int_q} + CNT_W'(stretch_q);
    assign tick     = en_q && (cnt_q == limit);
    assign acc_sum  = {1'b0, acc_q} + {1'b0, act_frac_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            stretch_q  <= 1'b0;
            cnt_q      <= '0;
            acc_q      <= '0;
            shd_int_q  <= '0;
            shd_frac_q <= '0;
            act_int_q  <= '0;
            act_frac_q <= '0;
        end else begin
            if (wr_hit) begin
                shd_int_q  <= wr_int;
                shd_frac_q <= wr_frac;
                en_q       <= wr_enable;
            end
            if (!en_q) begin
                cnt_q      <= '0;
                acc_q      <= '0;
                stretch_q  <= 1'b0;
                act_int_q  <= nxt_int;
                act_frac_q <= nxt_frac;
            end else if (tick) begin
                cnt_q      <= '0;
                acc_q      <= acc_sum[FRAC_W-1:0];
                stretch_q  <= acc_sum[FRAC_W];
                act_int_q  <= nxt_int;
                act_frac_q <= nxt_frac;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkdiv_route.sv
module clkdiv_route
    import clkdiv_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    map_we,
    input  logic [CH_W-1:0]         map_chan,
    input  div_sel_t                map_sel,
    input  logic                    map_on,
    output logic [NUM_CH-1:0]       rt_on,
    output div_sel_t [NUM_CH-1:0]   rt_sel,
    output logic                    map_conflict
);
    logic clash;

    always_comb begin
        clash = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (CH_W'(c) != map_chan && rt_on[c] && rt_sel[c] == map_sel)
                clash = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_on        <= '0;
            rt_sel       <= '0;
            map_conflict <= 1'b0;
        end else begin
            map_conflict <= map_we && map_on && clash;
            if (map_we && !(map_on && clash)) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (CH_W'(c) == map_chan) begin
                        rt_on[c]  <= map_on;
                        rt_sel[c] <= map_sel;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/clkdiv_pool.sv
module clkdiv_pool
    import clkdiv_pkg::*;
#(
    parameter int N_INT8   = 9,
    parameter int N_INT16  = 16,
    parameter int N_FRAC16 = 7,
    parameter int N_FRAC24 = 3,
    parameter int NUM_CH   = 4,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_type,
    input  logic [SEL_W-1:0]  cfg_idx,
    input  logic [VAL_W-1:0]  cfg_int,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic              cfg_enable,
    input  logic              map_we,
    input  logic [CH_W-1:0]   map_chan,
    input  logic [1:0]        map_type,
    input  logic [SEL_W-1:0]  map_idx,
    input  logic              map_on,
    output logic              map_conflict,
    output logic [NUM_CH-1:0] pclk_en
);
    localparam int NT = 4;
    localparam int COUNTS [NT] = '{N_INT8, N_INT16, N_FRAC16, N_FRAC24};
    localparam int MAX_N = 32;

    logic [MAX_N-1:0]     ticks [NT];
    logic [NUM_CH-1:0]    rt_on;
    div_sel_t [NUM_CH-1:0] rt_sel;
    logic [NUM_CH-1:0]    sel_tick;
    div_sel_t             map_sel;

    assign map_sel = '{typ: div_type_e'(map_type), idx: map_idx};

    for (genvar t = 0; t < NT; t++) begin : g_type
        localparam div_type_e TT = div_type_e'(t);
        localparam int        W  = type_width(TT);
        for (genvar i = 0; i < MAX_N; i++) begin : g_div
            if (i < COUNTS[t]) begin : g_real
                logic              hit;
                logic [FRAC_W-1:0] frac_in;
                assign hit     = cfg_we && cfg_type == 2'(t) && cfg_idx == SEL_W'(i);
                if (type_has_frac(TT)) begin : g_frac
                    assign frac_in = cfg_frac;
                end else begin : g_int
                    assign frac_in = '0;
                end
                clkdiv_unit #(.INT_W(W)) u_div (
                    .clk       (clk),
                    .rst       (rst),
                    .wr_hit    (hit),
                    .wr_int    (cfg_int[W-1:0]),
                    .wr_frac   (frac_in),
                    .wr_enable (cfg_enable),
                    .tick      (ticks[t][i])
                );
            end else begin : g_none
                assign ticks[t][i] = 1'b0;
            end
        end
    end

    clkdiv_route #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_route (
        .clk          (clk),
        .rst          (rst),
        .map_we       (map_we),
        .map_chan     (map_chan),
        .map_sel      (map_sel),
        .map_on       (map_on),
        .rt_on        (rt_on),
        .rt_sel       (rt_sel),
        .map_conflict (map_conflict)
    );

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            sel_tick[c] = rt_on[c] && ticks[rt_sel[c].typ][rt_sel[c].idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pclk_en <= '0;
        else     pclk_en <= sel_tick;
    end
endmodule

// File: rtl/clkdiv_pool_chk.sv
module clkdiv_pool_chk
    import clkdiv_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  map_we,
    input logic                  map_on,
    input logic                  map_conflict,
    input logic [NUM_CH-1:0]     pclk_en,
    input logic [NUM_CH-1:0]     rt_on,
    input div_sel_t [NUM_CH-1:0] rt_sel
);
    logic dup;

    always_comb begin
        dup = 1'b0;
        for (int a = 0; a < NUM_CH; a++)
            for (int b = a + 1; b < NUM_CH; b++)
                if (rt_on[a] && rt_on[b] && rt_sel[a] == rt_sel[b]) dup = 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (pclk_en == '0 && !map_conflict));

    assert_single_owner_R8: assert property (@(posedge clk) disable iff (rst)
        !dup);

    assert_conflict_cause_R8: assert property (@(posedge clk) disable iff (rst)
        map_conflict |-> $past(map_we && map_on));

    assert_refused_keeps_map_R8: assert property (@(posedge clk) disable iff (rst)
        map_conflict |-> ($stable(rt_on) && $stable(rt_sel)));

    assert_gated_by_map_R9: assert property (@(posedge clk) disable iff (rst)
        (pclk_en & ~$past(rt_on)) == '0);
endmodule

bind clkdiv_pool clkdiv_pool_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .map_we       (map_we),
    .map_on       (map_on),
    .map_conflict (map_conflict),
    .pclk_en      (pclk_en),
    .rt_on        (rt_on),
    .rt_sel       (rt_sel)
);

// File: tb/clkdiv_pool_test.sv
module clkdiv_pool_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0, cfg_enable = 0, map_we = 0, map_on = 0;
    logic [1:0]  cfg_type = 0, map_type = 0, map_chan = 0;
    logic [4:0]  cfg_idx = 0, cfg_frac = 0, map_idx = 0;
    logic [23:0] cfg_int = 0;
    logic        map_conflict;
    logic [3:0]  pclk_en;
    int vecs = 0, errs = 0;

    always #10 clk = ~clk;

    clkdiv_pool uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_type(cfg_type), .cfg_idx(cfg_idx),
        .cfg_int(cfg_int), .cfg_frac(cfg_frac), .cfg_enable(cfg_enable),
        .map_we(map_we), .map_chan(map_chan), .map_type(map_type), .map_idx(map_idx),
        .map_on(map_on), .map_conflict(map_conflict), .pclk_en(pclk_en)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // caller is at a falling edge; returns at the falling edge after the write edge
    task automatic cfg(input int t, input int i, input int n, input int f, input bit en);
        cfg_we = 1; cfg_type = 2'(t); cfg_idx = 5'(i); cfg_int = 24'(n);
        cfg_frac = 5'(f); cfg_enable = en;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic map(input int ch, input int t, input int i, input bit on);
        map_we = 1; map_chan = 2'(ch); map_type = 2'(t); map_idx = 5'(i); map_on = on;
        @(negedge clk);
        map_we = 0;
    endtask

    task automatic wait_pulse(input int ch, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pclk_en[ch] && n < 20000);
    endtask

    task automatic count_pulses(input int ch, input int cyc, output int n);
        n = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (pclk_en[ch]) n++;
        end
    endtask

    task automatic frac_run(input int ch, input int t, input int i, input int n, input int f);
        int sp, sum, bad;
        cfg(t, i, n, f, 0);
        cfg(t, i, n, f, 1);
        wait_pulse(ch, sp);
        wait_pulse(ch, sp);
        sum = 0; bad = 0;
        for (int p = 0; p < 32; p++) begin
            wait_pulse(ch, sp);
            sum += sp;
            if (sp != n + 1 && sp != n + 2) bad++;
        end
        chk(bad == 0, "R3 period length", bad, 0);
        chk(sum == 32 * (n + 1) + f, "R3 sum of 32 periods", sum, 32 * (n + 1) + f);
    endtask

    initial begin
        int sp, np;
        repeat (3) @(negedge clk);
        chk(pclk_en == 0, "R1 pclk_en in reset", pclk_en, 0);
        rst = 0;
        @(negedge clk);
        chk(pclk_en == 0 && !map_conflict, "R1 outputs after reset", {map_conflict, pclk_en}, 0);
        map(0, 0, 0, 1);
        count_pulses(0, 20, np);
        chk(np == 0, "R1 dividers disabled after reset", np, 0);

        // R5 first pulse, R2 spacing
        cfg(0, 0, 4, 0, 1);
        wait_pulse(0, sp);
        chk(sp == 5, "R5 first pulse latency N=4", sp, 5);
        for (int k = 0; k < 3; k++) begin
            wait_pulse(0, sp);
            chk(sp == 5, "R2 int8 spacing N=4", sp, 5);
        end

        // R2/R5/R7 sweep of int8 values
        for (int n = 0; n <= 12; n++) begin
            cfg(0, 0, n, 0, 0);
            cfg(0, 0, n, 0, 1);
            wait_pulse(0, sp);
            chk(sp == n + 1, "R5 latency sweep", sp, n + 1);
            for (int k = 0; k < 2; k++) begin
                wait_pulse(0, sp);
                chk(sp == n + 1, "R2 int8 sweep spacing", sp, n + 1);
            end
        end

        // R2 16-bit integer ignores fraction, R4 last index on another channel
        map(1, 1, 15, 1);
        cfg(1, 15, 300, 31, 1);
        wait_pulse(1, sp);
        np = 0;
        for (int p = 0; p < 32; p++) begin wait_pulse(1, sp); np += sp; end
        chk(np == 32 * 301, "R2 int16 ignores fraction", np, 32 * 301);

        // R3 fractional sweep
        map(2, 2, 6, 1);
        for (int f = 0; f < 32; f++) frac_run(2, 2, 6, 1, f);
        map(3, 3, 2, 1);
        frac_run(3, 3, 2, 9, 31);
        frac_run(3, 3, 2, 0, 16);

        // R4 out-of-range index gives nothing
        map(3, 2, 10, 1);
        count_pulses(3, 50, np);
        chk(np == 0, "R4 out-of-range index", np, 0);
        // R9 unmapped channel stays quiet while its divider runs
        map(3, 3, 2, 0);
        count_pulses(3, 50, np);
        chk(np == 0, "R9 unmapped channel", np, 0);
        map(3, 3, 2, 1);
        wait_pulse(3, sp);
        wait_pulse(3, sp);
        chk(sp == 1 || sp == 2, "R4 remap pulses again", sp, 1);

        // R6 live update
        cfg(0, 0, 9, 0, 1);
        wait_pulse(0, sp);
        wait_pulse(0, sp);
        cfg(0, 0, 3, 0, 1);
        wait_pulse(0, sp);
        chk(sp + 1 == 10, "R6 current period kept", sp + 1, 10);
        wait_pulse(0, sp);
        chk(sp == 4, "R6 next period new value", sp, 4);

        // R7 disable and restart
        cfg(0, 0, 3, 0, 0);
        count_pulses(0, 60, np);
        chk(np == 0, "R7 disabled silent", np, 0);
        cfg(0, 0, 3, 0, 1);
        wait_pulse(0, sp);
        chk(sp == 4, "R7 restart latency", sp, 4);

        // R8 ownership
        map(0, 1, 15, 1);
        chk(map_conflict == 1, "R8 conflict flagged", map_conflict, 1);
        @(negedge clk);
        chk(map_conflict == 0, "R8 conflict single cycle", map_conflict, 0);
        wait_pulse(0, sp);
        wait_pulse(0, sp);
        chk(sp == 4, "R8 refused map unchanged", sp, 4);
        map(1, 1, 15, 1);
        chk(map_conflict == 0, "R8 remap own divider", map_conflict, 0);
        map(1, 1, 15, 0);
        chk(map_conflict == 0, "R8 unmap accepted", map_conflict, 0);
        map(0, 1, 15, 1);
        chk(map_conflict == 0, "R8 freed divider taken", map_conflict, 0);
        wait_pulse(0, sp);
        wait_pulse(0, sp);
        chk(sp == 301, "R8 new owner spacing", sp, 301);
        count_pulses(1, 320, np);
        chk(np == 0, "R9 released channel quiet", np, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vecs++; errs++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule